// File: doc/BRIEF.md
# Autobaud Addressed Frame Receiver

This block is the receive front end of a node on a shared multi-drop serial line. Each frame opens with a timing character (0x55). The receiver measures the bit period from that character and then samples every following byte of the same frame at that rate. A frame may arrive at any rate the node can follow, and the next frame may use a different rate.

Frames are delimited by long idle-high gaps on the line. The byte after the timing character is a destination address. The receiver passes on only frames that name this node and whose rate is not faster than the node's configured limit. Rejected traffic is skipped until the next gap. Accepted frames produce a start pulse, then one strobed byte per payload character, then an end pulse when the closing gap is seen.

Top module: `baudsync_frame_rx`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `frameStart`, `dataValid` and `frameEnd` are all low.
- R2: The bit period equals the clock count from the falling edge that opens the 0x55 start bit to the fifth falling edge, where bit 7 begins, divided by 8. Bytes are 8N1, least significant bit first, and each bit is sampled near its middle using that period. Periods of 16, 21 and 32 clocks in successive frames all decode correctly.
- R3: A break is the line held high for just over 12 measured bit periods. An idle-high run of 11 bit periods inside a frame, counting the stop bit, does not end the frame.
- R4: When the first byte after 0x55 differs from `nodeAddr`, no pulse or byte is produced for that frame and reception resumes only after the next break.
- R5: When the measured period is below `minPeriod`, the frame produces no output even if its address matches. The break that follows that frame is still detected at 12 of the fast measured periods.
- R6: A payload byte whose stop bit samples low is discarded, along with the rest of its frame. `frameEnd` is still given at the next break when `frameStart` was given for that frame.
- R7: `frameStart` pulses for one cycle after a matching address byte. Each payload byte then pulses `dataValid` for one cycle with the byte on `dataOut`. `frameEnd` pulses for one cycle at the break that follows an accepted frame. At most one of the three is high in any cycle.
- R8: After reset, all line activity is ignored until a first break, which uses a default length of 12 × `MAX_PERIOD` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial line, already synchronised to `clk`, idle high |
| nodeAddr | input | 8 | Address this node answers to |
| minPeriod | input | PER_W | Shortest bit period, in clocks, the node accepts |
| dataOut | output | 8 | Last received payload byte |
| dataValid | output | 1 | One-cycle strobe when `dataOut` holds a new payload byte |
| frameStart | output | 1 | One-cycle pulse when a frame is accepted |
| frameEnd | output | 1 | One-cycle pulse at the break closing an accepted frame |

## Verification
On every cycle, assertions check several properties. The three output pulses never overlap. A start pulse only follows an address equal to `nodeAddr` and a period at or above `minPeriod`. Bytes and end pulses occur only inside an accepted frame. The receiver stays silent while it waits for a break, and the break detector fires for one cycle only. Other properties need the bench's scenarios: that the measured period really tracks the rate the sender used, that a gap one bit period short of the threshold leaves a frame open, and that the break after a too-fast frame uses that frame's own period. The bench covers these with frames at several rates, a rejected fast frame followed by a short gap, a mismatched address, a frame traffic burst before the first break, and a low stop bit.

// File: rtl/bsrx_pkg.sv
package bsrx_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_BREAK,
    ST_SYNC_IDLE,
    ST_SYNC_MEAS,
    ST_SYNC_STOP,
    ST_BYTE_IDLE,
    ST_BYTE_RX
  } rx_state_e;

  typedef struct packed {
    logic measClr;       // restart the period measurement counter
    logic periodLatch;   // capture the measured period
    logic loadHalf;      // arm the bit timer with half a period
    logic loadSyncStop;  // arm the bit timer to the middle of the sync stop bit
    logic shiftBit;      // shift the sampled line bit into the byte register
    logic reloadOnTick;  // bit timer reloads a full period after each tick
  } dp_ctrl_t;

endpackage

// File: rtl/bsrx_datapath.sv
module bsrx_datapath
  import bsrx_pkg::*;
#(
  parameter int PER_W      = 13,
  parameter int MAX_PERIOD = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  dp_ctrl_t         ctrl,
  output logic             lineBit,
  output logic             fallEdge,
  output logic             tick,
  output logic             breakHit,
  output logic [PER_W-1:0] period,
  output logic [PER_W-1:0] periodNext,
  output logic [7:0]       byteData
);

  localparam int MEAS_W = PER_W + 3;
  localparam int BRK_W  = PER_W + 4;
  localparam int CNT_W  = PER_W + 1;

  logic              lineQ, linePrev;
  logic [MEAS_W-1:0] measCnt;
  logic [PER_W-1:0]  periodReg;
  logic [BRK_W-1:0]  highRun;
  logic [BRK_W-1:0]  breakLen;
  logic [CNT_W-1:0]  downCnt;
  logic [CNT_W-1:0]  halfVal;
  logic [CNT_W-1:0]  syncVal;
  logic [7:0]        shiftReg;

  // line registering and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ    <= 1'b1;
      linePrev <= 1'b1;
    end else begin
      lineQ    <= rxLine;
      linePrev <= lineQ;
    end
  end

  assign lineBit  = lineQ;
  assign fallEdge = linePrev & ~lineQ;

  // period measurement over eight bit times of the sync character
  always_ff @(posedge clk) begin
    if (!rstN) begin
      measCnt <= '0;
    end else if (ctrl.measClr) begin
      measCnt <= MEAS_W'(1);
    end else if (measCnt != '1) begin
      measCnt <= measCnt + 1'b1;
    end
  end

  assign periodNext = PER_W'(measCnt >> 3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= PER_W'(MAX_PERIOD);
    end else if (ctrl.periodLatch) begin
      periodReg <= periodNext;
    end
  end

  assign period = periodReg;

  // break detection: idle-high run of twelve measured periods
  assign breakLen = (BRK_W'(periodReg) << 3) + (BRK_W'(periodReg) << 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highRun <= '0;
    end else if (!lineQ) begin
      highRun <= '0;
    end else if (highRun != '1) begin
      highRun <= highRun + 1'b1;
    end
  end

  assign breakHit = lineQ && (highRun == breakLen);

  // bit timer
  assign halfVal = CNT_W'(periodReg >> 1);
  assign syncVal = CNT_W'(periodNext) + CNT_W'(periodNext >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      downCnt <= '0;
    end else if (ctrl.loadHalf) begin
      downCnt <= halfVal;
    end else if (ctrl.loadSyncStop) begin
      downCnt <= syncVal;
    end else if (downCnt != '0) begin
      if (downCnt == CNT_W'(1) && ctrl.reloadOnTick) begin
        downCnt <= CNT_W'(periodReg);
      end else begin
        downCnt <= downCnt - 1'b1;
      end
    end
  end

  assign tick = (downCnt == CNT_W'(1));

  // byte assembly, least significant bit first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctrl.shiftBit) begin
      shiftReg <= {lineQ, shiftReg[7:1]};
    end
  end

  assign byteData = shiftReg;

  // R3: a break is reported once per idle run
  p_break_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    breakHit |=> !breakHit);

endmodule

// File: rtl/bsrx_control.sv
module bsrx_control
  import bsrx_pkg::*;
#(
  parameter int PER_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fallEdge,
  input  logic             tick,
  input  logic             lineBit,
  input  logic             breakHit,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] periodNext,
  input  logic [7:0]       byteData,
  input  logic [7:0]       nodeAddr,
  input  logic [PER_W-1:0] minPeriod,
  output dp_ctrl_t         ctrl,
  output logic             frameStart,
  output logic             dataValid,
  output logic             frameEnd
);

  localparam logic [2:0] LAST_SYNC_EDGE = 3'd4;
  localparam logic [3:0] STOP_IDX       = 4'd9;

  rx_state_e  state;
  logic [2:0] edgeCnt;
  logic [3:0] bitIdx;
  logic       addrPhase;
  logic       accepted;
  logic       rateOk;

  assign rateOk = (periodNext >= minPeriod);

  always_comb begin
    ctrl = '0;
    ctrl.reloadOnTick = (state == ST_BYTE_RX);
    case (state)
      ST_SYNC_IDLE: ctrl.measClr = fallEdge;
      ST_SYNC_MEAS: begin
        if (fallEdge && edgeCnt == LAST_SYNC_EDGE) begin
          ctrl.periodLatch  = 1'b1;
          ctrl.loadSyncStop = rateOk;
        end
      end
      ST_BYTE_IDLE: ctrl.loadHalf = fallEdge;
      ST_BYTE_RX:   ctrl.shiftBit = tick && (bitIdx != 4'd0) && (bitIdx != STOP_IDX);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_WAIT_BREAK;
      edgeCnt    <= '0;
      bitIdx     <= '0;
      addrPhase  <= 1'b0;
      accepted   <= 1'b0;
      frameStart <= 1'b0;
      dataValid  <= 1'b0;
      frameEnd   <= 1'b0;
    end else begin
      frameStart <= 1'b0;
      dataValid  <= 1'b0;
      frameEnd   <= 1'b0;
      if (breakHit) begin
        state    <= ST_SYNC_IDLE;
        frameEnd <= accepted;
        accepted <= 1'b0;
      end else begin
        case (state)
          ST_SYNC_IDLE: begin
            if (fallEdge) begin
              state   <= ST_SYNC_MEAS;
              edgeCnt <= 3'd1;
            end
          end
          ST_SYNC_MEAS: begin
            if (fallEdge) begin
              if (edgeCnt == LAST_SYNC_EDGE) begin
                state <= rateOk ? ST_SYNC_STOP : ST_WAIT_BREAK;
              end else begin
                edgeCnt <= edgeCnt + 1'b1;
              end
            end
          end
          ST_SYNC_STOP: begin
            if (tick) begin
              if (lineBit) begin
                state     <= ST_BYTE_IDLE;
                addrPhase <= 1'b1;
              end else begin
                state <= ST_WAIT_BREAK;
              end
            end
          end
          ST_BYTE_IDLE: begin
            if (fallEdge) begin
              state  <= ST_BYTE_RX;
              bitIdx <= '0;
            end
          end
          ST_BYTE_RX: begin
            if (tick) begin
              if (bitIdx == 4'd0 && lineBit) begin
                state <= ST_BYTE_IDLE;             // glitch, not a start bit
              end else if (bitIdx == STOP_IDX) begin
                if (!lineBit) begin
                  state <= ST_WAIT_BREAK;          // framing error
                end else if (addrPhase) begin
                  addrPhase <= 1'b0;
                  if (byteData == nodeAddr) begin
                    state      <= ST_BYTE_IDLE;
                    frameStart <= 1'b1;
                    accepted   <= 1'b1;
                  end else begin
                    state <= ST_WAIT_BREAK;
                  end
                end else begin
                  state     <= ST_BYTE_IDLE;
                  dataValid <= 1'b1;
                end
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: output pulses never overlap
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStart, dataValid, frameEnd}));

  // R7: bytes only inside an accepted frame
  p_data_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> accepted);

  // R7: an end pulse closes a frame that was accepted
  p_end_needs_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> $past(accepted));

  // R4: acceptance only on a matching address
  p_addr_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (byteData == nodeAddr));

  // R5: acceptance only at an allowed rate
  p_rate_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (period >= minPeriod));

  // R6 and R8: silent while waiting for a break
  p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_BREAK && $past(state) == ST_WAIT_BREAK) |-> (!frameStart && !dataValid));

endmodule

// File: rtl/baudsync_frame_rx.sv
module baudsync_frame_rx
  import bsrx_pkg::*;
#(
  parameter int PER_W      = 13,
  parameter int MAX_PERIOD = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxLine,
  input  logic [7:0]       nodeAddr,
  input  logic [PER_W-1:0] minPeriod,
  output logic [7:0]       dataOut,
  output logic             dataValid,
  output logic             frameStart,
  output logic             frameEnd
);

  dp_ctrl_t         ctrl;
  logic             lineBit, fallEdge, tick, breakHit;
  logic [PER_W-1:0] period, periodNext;
  logic [7:0]       byteData;

  bsrx_datapath #(.PER_W(PER_W), .MAX_PERIOD(MAX_PERIOD)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .ctrl       (ctrl),
    .lineBit    (lineBit),
    .fallEdge   (fallEdge),
    .tick       (tick),
    .breakHit   (breakHit),
    .period     (period),
    .periodNext (periodNext),
    .byteData   (byteData)
  );

  bsrx_control #(.PER_W(PER_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .fallEdge   (fallEdge),
    .tick       (tick),
    .lineBit    (lineBit),
    .breakHit   (breakHit),
    .period     (period),
    .periodNext (periodNext),
    .byteData   (byteData),
    .nodeAddr   (nodeAddr),
    .minPeriod  (minPeriod),
    .ctrl       (ctrl),
    .frameStart (frameStart),
    .dataValid  (dataValid),
    .frameEnd   (frameEnd)
  );

  assign dataOut = byteData;

endmodule

// File: tb/tb_baudsync_frame_rx.sv
module tb_baudsync_frame_rx;

  localparam int PER_W   = 13;
  localparam int MAXP    = 40;
  localparam logic [7:0] MY_ADDR = 8'h3A;

  typedef struct {
    int         kind;   // 1 start, 2 data, 3 end
    logic [7:0] data;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rxLine = 1'b0;
  logic [7:0]       nodeAddr = MY_ADDR;
  logic [PER_W-1:0] minPeriod = PER_W'(12);
  logic [7:0]       dataOut;
  logic             dataValid, frameStart, frameEnd;

  int   compared = 0;
  int   mismatched = 0;
  bit   finished = 0;
  exp_t expQ[$];

  always #2 clk = ~clk;   // 250 MHz

  baudsync_frame_rx #(.PER_W(PER_W), .MAX_PERIOD(MAXP)) dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .nodeAddr(nodeAddr),
    .minPeriod(minPeriod), .dataOut(dataOut), .dataValid(dataValid),
    .frameStart(frameStart), .frameEnd(frameEnd)
  );

  task automatic expect_ev(int kind, logic [7:0] data, string tag);
    exp_t e;
    e.kind = kind; e.data = data; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic hold(logic v, int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, int p, bit stopOk);
    hold(1'b0, p);
    for (int i = 0; i < 8; i++) hold(b[i], p);
    hold(stopOk, p);
    rxLine = 1'b1;
  endtask

  // sync, address, payload; gap of two bit periods between characters
  task automatic send_frame(int p, logic [7:0] addr, logic [7:0] pay[], bit accept, string tag);
    if (accept) begin
      expect_ev(1, 8'h00, tag);
      foreach (pay[i]) expect_ev(2, pay[i], tag);
    end
    send_byte(8'h55, p, 1'b1);
    hold(1'b1, 2 * p);
    send_byte(addr, p, 1'b1);
    hold(1'b1, 2 * p);
    foreach (pay[i]) begin
      send_byte(pay[i], p, 1'b1);
      hold(1'b1, 2 * p);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && (frameStart || dataValid || frameEnd)) begin
      int k;
      k = frameStart ? 1 : (dataValid ? 2 : 3);
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R1 R4 R5 R6 R8 unexpected output: actual kind=%0d data=%h expected none",
                 k, dataOut);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (k != e.kind || (k == 2 && dataOut !== e.data)) begin
          mismatched++;
          $display("FAIL %s: actual kind=%0d data=%h expected kind=%0d data=%h",
                   e.tag, k, dataOut, e.kind, e.data);
        end
      end
    end
  end

  initial begin
    logic [7:0] p2[];
    logic [7:0] p3[];
    logic [7:0] p4[];
    logic [7:0] p5[];
    logic [7:0] none[];
    none = new[0];

    // R1: reset state, line held low
    repeat (5) @(negedge clk);
    compared++;
    if (frameStart || dataValid || frameEnd) begin
      mismatched++;
      $display("FAIL R1 during reset: actual %b%b%b expected 000", frameStart, dataValid, frameEnd);
    end
    rstN = 1'b1;
    @(negedge clk);
    compared++;
    if (frameStart || dataValid || frameEnd) begin
      mismatched++;
      $display("FAIL R1 after reset: actual %b%b%b expected 000", frameStart, dataValid, frameEnd);
    end

    // R8: matching frame before any break is ignored
    p2 = new[2]; p2[0] = 8'h12; p2[1] = 8'h34;
    hold(1'b1, 20);
    send_frame(16, MY_ADDR, p2, 1'b0, "R8");
    hold(1'b1, 12 * MAXP + 40);        // default break length

    // R2 R7: accepted frame at 16 clocks per bit
    p3 = new[3]; p3[0] = 8'h00; p3[1] = 8'hFF; p3[2] = 8'hA5;
    send_frame(16, MY_ADDR, p3, 1'b1, "R2 R7 rate16");
    expect_ev(3, 8'h00, "R7 end rate16");
    hold(1'b1, 14 * 16);

    // R2 R3: 32 clocks per bit, 10-period gap inside the frame keeps it open
    p4 = new[2]; p4[0] = 8'h81; p4[1] = 8'h5A;
    send_frame(32, MY_ADDR, p4, 1'b1, "R2 rate32");
    expect_ev(2, 8'h7E, "R3 byte after short gap");
    hold(1'b1, 8 * 32);                // total high run 11 periods with the stop bit
    send_byte(8'h7E, 32, 1'b1);
    expect_ev(3, 8'h00, "R3 end rate32");
    hold(1'b1, 14 * 32);

    // R5: too fast, ignored; its short break still re-arms
    send_frame(8, MY_ADDR, p3, 1'b0, "R5");
    hold(1'b1, 14 * 8);
    send_frame(21, MY_ADDR, p4, 1'b1, "R2 R5 rate21 after fast break");
    expect_ev(3, 8'h00, "R5 end rate21");
    hold(1'b1, 14 * 21);

    // R4: address mismatch ignored
    send_frame(16, 8'h3B, p3, 1'b0, "R4");
    hold(1'b1, 14 * 16);

    // R6: low stop bit drops the rest, end still reported
    p5 = new[1]; p5[0] = 8'h11;
    send_frame(16, MY_ADDR, p5, 1'b1, "R6 before error");
    send_byte(8'h22, 16, 1'b0);
    hold(1'b1, 2 * 16);
    send_byte(8'h33, 16, 1'b1);
    expect_ev(3, 8'h00, "R6 end after framing error");
    hold(1'b1, 14 * 16);

    // recovery: header only frame, then one-byte frame
    send_frame(16, MY_ADDR, none, 1'b1, "R7 empty frame");
    expect_ev(3, 8'h00, "R7 end empty");
    hold(1'b1, 14 * 16);
    p5[0] = 8'hC3;
    send_frame(16, MY_ADDR, p5, 1'b1, "R7 recovery");
    expect_ev(3, 8'h00, "R7 end recovery");
    hold(1'b1, 14 * 16 + 50);

    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R7 missing events: actual outstanding=%0d expected 0", expQ.size());
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R7: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule